// File: doc/BRIEF.md
# Temperature Sample Linearizer

This block turns a raw count from an on-die temperature sensor into a signed temperature in millidegrees Celsius. The conversion is affine in the count. The slope comes from two coefficients, a gain and a full-scale count. An offset comes from a third coefficient. A correction term scales a signed fourth coefficient by the sensor clock frequency, which is given in Hz. The result is saturated to the operating window of the sensor.

Each of the four coefficients sits in its own register. A load strobe fills all four registers with one of two built-in preset sets. After that, single writes may override any coefficient. A conversion starts when a sample is presented while the block is idle. The block then runs two sequential restoring divisions, one bit per cycle. The first divides by the full-scale count, and the second removes the frequency scale of one million. A one-cycle valid pulse carries the clamped result. If the full-scale count is zero, no division takes place: the block raises an error pulse and produces no result.

Top module: `tsense_linearizer`

## Requirements
- R1: After synchronous reset, busy, result_valid and div_err are low and result_mc is 0. The coefficient registers hold the first preset set: gain 200000, offset 60000, frequency coefficient -100, full-scale count 4094.
- R2: A result equals offset + trunc(gain*n / fullscale) - trunc(gain/2) + trunc(fcoef*freq_hz / 1000000). The arithmetic is signed 64-bit and every division truncates toward zero.
- R3: result_mc is clamped to the range -40000 to 125000 inclusive.
- R4: Only sample_raw[15:0] is used as n. The upper bits of sample_raw have no effect on the result.
- R5: A cycle with preset_load high loads all four coefficients from a preset set. preset_sel=0 selects the first set. preset_sel=1 selects the second set: gain 249400, offset 57400, frequency coefficient 0, full-scale count 4096.
- R6: A cycle with coef_we high writes coef_wdata into the coefficient named by coef_addr. The codes are 0 for gain, 1 for offset, 2 for the frequency coefficient (two's complement) and 3 for the full-scale count.
- R7: A sample is accepted only when busy is low. busy rises in the cycle after acceptance and falls in the same cycle that result_valid rises. A sample presented while busy is high is ignored and produces no result.
- R8: If an accepted sample meets a full-scale count of zero, div_err pulses high for one cycle in the next cycle. result_valid does not rise and busy stays low.
- R9: result_valid is high for a single cycle. result_mc keeps its value until the next result.
- R10: If preset_load and coef_we are high in the same cycle, the preset load wins and the write is discarded.
- R11: The coefficients and freq_hz are captured when a sample is accepted. Writes made during a conversion do not change that conversion's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| preset_load | input | 1 | Load the selected preset set into all coefficients |
| preset_sel | input | 1 | Preset choice: 0 first set, 1 second set |
| coef_we | input | 1 | Single coefficient write strobe |
| coef_addr | input | 2 | Coefficient select: 0 gain, 1 offset, 2 frequency coefficient, 3 full-scale count |
| coef_wdata | input | 32 | Coefficient write value |
| freq_hz | input | 32 | Sensor clock frequency in Hz |
| sample_valid | input | 1 | Raw sample present |
| sample_raw | input | 32 | Raw sensor word; the low 16 bits are the count |
| busy | output | 1 | Conversion in progress |
| result_valid | output | 1 | One-cycle result strobe |
| result_mc | output | 32 | Signed temperature in millidegrees Celsius |
| div_err | output | 1 | One-cycle pulse: sample rejected because the full-scale count is zero |

## Verification
On every cycle the checker covers the following:
- Each result lies inside the clamp window.
- The valid strobe lasts one cycle and the result holds between strobes.
- busy rises after an accepted sample and falls together with the strobe.
- A zero full-scale count leads to the error pulse without busy or a result.

Only the bench scenarios can show the arithmetic. That includes truncation toward zero of a negative frequency correction, the effect of each preset set, the masking of the upper sample bits, and the priority of a preset load over a same-cycle write. They can also show that writes during a conversion leave its result alone. The bench compares these against a 64-bit reference model, using both directed and random coefficient sets.

// File: rtl/tlin_pkg.sv
package tlin_pkg;

  localparam int unsigned COEF_W     = 32;
  localparam int unsigned FREQ_SCALE = 1000000;
  localparam longint      TEMP_LO_MC = -40000;
  localparam longint      TEMP_HI_MC = 125000;

  typedef struct packed {
    logic        [COEF_W-1:0] gain;
    logic        [COEF_W-1:0] offs;
    logic signed [COEF_W-1:0] fco;
    logic        [COEF_W-1:0] fsc;
  } coef_t;

  typedef enum logic [1:0] {
    CA_GAIN = 2'd0,
    CA_OFFS = 2'd1,
    CA_FCO  = 2'd2,
    CA_FSC  = 2'd3
  } coef_addr_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIV_SLOPE,
    ST_DIV_FREQ,
    ST_SUM
  } lin_state_e;

  function automatic coef_t preset_of(input logic sel);
    coef_t c;
    if (sel) begin
      c.gain = 32'd249400;
      c.offs = 32'd57400;
      c.fco  = 32'sd0;
      c.fsc  = 32'd4096;
    end else begin
      c.gain = 32'd200000;
      c.offs = 32'd60000;
      c.fco  = -32'sd100;
      c.fsc  = 32'd4094;
    end
    return c;
  endfunction

endpackage

// File: rtl/tlin_coef_bank.sv
module tlin_coef_bank
  import tlin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              sel,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [COEF_W-1:0] wdata,
  output coef_t             coef
);

  always_ff @(posedge clk) begin
    if (rst) begin
      coef <= preset_of(1'b0);
    end else if (load) begin
      coef <= preset_of(sel);
    end else if (we) begin
      case (coef_addr_e'(addr))
        CA_GAIN: coef.gain <= wdata;
        CA_OFFS: coef.offs <= wdata;
        CA_FCO:  coef.fco  <= $signed(wdata);
        default: coef.fsc  <= wdata;
      endcase
    end
  end

endmodule

// File: rtl/tlin_sdiv.sv
module tlin_sdiv #(
  parameter int NUM_W = 64,
  parameter int DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quot
);

  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] q_sr;
  logic [DEN_W-1:0] rem;
  logic [DEN_W-1:0] den_r;
  logic [CNT_W-1:0] cnt;
  logic             active;

  logic [DEN_W:0]   trial;
  logic             fit;
  logic [DEN_W-1:0] rem_nx;

  always_comb begin
    trial  = {rem, q_sr[NUM_W-1]};
    fit    = (trial >= {1'b0, den_r});
    rem_nx = fit ? DEN_W'(trial - {1'b0, den_r}) : trial[DEN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      q_sr   <= '0;
      rem    <= '0;
      den_r  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q_sr   <= num;
        rem    <= '0;
        den_r  <= den;
        cnt    <= CNT_W'(NUM_W);
        active <= 1'b1;
      end else if (active) begin
        q_sr <= {q_sr[NUM_W-2:0], fit};
        rem  <= rem_nx;
        cnt  <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  assign quot = q_sr;

endmodule

// File: rtl/tlin_clamp.sv
module tlin_clamp #(
  parameter int     IN_W  = 64,
  parameter int     OUT_W = 32,
  parameter longint LO    = -40000,
  parameter longint HI    = 125000
) (
  input  logic signed [IN_W-1:0]  val_in,
  output logic signed [OUT_W-1:0] val_out
);

  localparam logic signed [IN_W-1:0] LO_V = IN_W'(LO);
  localparam logic signed [IN_W-1:0] HI_V = IN_W'(HI);

  always_comb begin
    if (val_in < LO_V)      val_out = OUT_W'(LO_V);
    else if (val_in > HI_V) val_out = OUT_W'(HI_V);
    else                    val_out = OUT_W'(val_in);
  end

endmodule

// File: rtl/tsense_linearizer.sv
module tsense_linearizer
  import tlin_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int RAW_W    = 32,
  parameter int FREQ_W   = 32,
  parameter int RES_W    = 32,
  parameter int ACC_W    = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    preset_load,
  input  logic                    preset_sel,
  input  logic                    coef_we,
  input  logic [1:0]              coef_addr,
  input  logic [COEF_W-1:0]       coef_wdata,
  input  logic [FREQ_W-1:0]       freq_hz,
  input  logic                    sample_valid,
  input  logic [RAW_W-1:0]        sample_raw,
  output logic                    busy,
  output logic                    result_valid,
  output logic signed [RES_W-1:0] result_mc,
  output logic                    div_err
);

  coef_t             coef;
  coef_t             snap;
  logic [FREQ_W-1:0] f_snap;
  lin_state_e        st;
  logic [COEF_W-1:0] cal_live;

  logic              div_go;
  logic              div_done;
  logic [ACC_W-1:0]  div_num;
  logic [COEF_W-1:0] div_den;
  logic [ACC_W-1:0]  div_q;

  logic [ACC_W-1:0]        slope_q;
  logic signed [ACC_W-1:0] fcorr_q;
  logic                    fneg_q;

  logic [ACC_W-1:0]        slope_prod;
  logic signed [ACC_W-1:0] j_ext;
  logic signed [ACC_W-1:0] f_ext;
  logic signed [ACC_W-1:0] jf_prod;
  logic [ACC_W-1:0]        jf_mag;
  logic [ACC_W-1:0]        g_ext;
  logic [ACC_W-1:0]        hh_ext;
  logic signed [ACC_W-1:0] sum;
  logic signed [RES_W-1:0] clamped;

  tlin_coef_bank u_bank (
    .clk   (clk),
    .rst   (rst),
    .load  (preset_load),
    .sel   (preset_sel),
    .we    (coef_we),
    .addr  (coef_addr),
    .wdata (coef_wdata),
    .coef  (coef)
  );

  tlin_sdiv #(.NUM_W(ACC_W), .DEN_W(COEF_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (div_go),
    .num   (div_num),
    .den   (div_den),
    .done  (div_done),
    .quot  (div_q)
  );

  tlin_clamp #(.IN_W(ACC_W), .OUT_W(RES_W), .LO(TEMP_LO_MC), .HI(TEMP_HI_MC)) u_clamp (
    .val_in  (sum),
    .val_out (clamped)
  );

  assign cal_live   = coef.fsc;
  assign slope_prod = ACC_W'(coef.gain) * ACC_W'(sample_raw[SAMPLE_W-1:0]);
  assign j_ext      = {{(ACC_W-COEF_W){snap.fco[COEF_W-1]}}, snap.fco};
  assign f_ext      = {{(ACC_W-FREQ_W){1'b0}}, f_snap};
  assign jf_prod    = j_ext * f_ext;
  assign jf_mag     = jf_prod[ACC_W-1] ? ACC_W'(-jf_prod) : ACC_W'(jf_prod);
  assign g_ext      = {{(ACC_W-COEF_W){1'b0}}, snap.offs};
  assign hh_ext     = {{(ACC_W-COEF_W+1){1'b0}}, snap.gain[COEF_W-1:1]};
  assign sum        = $signed(g_ext) + $signed(slope_q) - $signed(hh_ext) + fcorr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      busy         <= 1'b0;
      result_valid <= 1'b0;
      result_mc    <= '0;
      div_err      <= 1'b0;
      div_go       <= 1'b0;
      div_num      <= '0;
      div_den      <= '0;
      snap         <= '0;
      f_snap       <= '0;
      slope_q      <= '0;
      fcorr_q      <= '0;
      fneg_q       <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      div_err      <= 1'b0;
      div_go       <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (sample_valid) begin
            snap   <= coef;
            f_snap <= freq_hz;
            if (cal_live == '0) begin
              div_err <= 1'b1;
            end else begin
              div_num <= slope_prod;
              div_den <= cal_live;
              div_go  <= 1'b1;
              busy    <= 1'b1;
              st      <= ST_DIV_SLOPE;
            end
          end
        end
        ST_DIV_SLOPE: begin
          if (div_done) begin
            slope_q <= div_q;
            div_num <= jf_mag;
            div_den <= COEF_W'(FREQ_SCALE);
            fneg_q  <= jf_prod[ACC_W-1];
            div_go  <= 1'b1;
            st      <= ST_DIV_FREQ;
          end
        end
        ST_DIV_FREQ: begin
          if (div_done) begin
            fcorr_q <= fneg_q ? -$signed(div_q) : $signed(div_q);
            st      <= ST_SUM;
          end
        end
        default: begin
          result_mc    <= clamped;
          result_valid <= 1'b1;
          busy         <= 1'b0;
          st           <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/tlin_checks.sv
module tlin_checks #(
  parameter int RES_W = 32,
  parameter int CAL_W = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    sample_valid,
  input logic                    busy,
  input logic                    result_valid,
  input logic signed [RES_W-1:0] result_mc,
  input logic                    div_err,
  input logic [CAL_W-1:0]        cal_now
);

  assert_clamp_window_R3: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> (result_mc >= -40000 && result_mc <= 125000));

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && !busy && cal_now != '0) |=> busy);

  assert_busy_drops_with_result_R7: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> (!busy && $past(busy)));

  assert_zero_fsc_error_R8: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && !busy && cal_now == '0) |=> (div_err && !busy));

  assert_error_excludes_result_R8: assert property (@(posedge clk) disable iff (rst)
    !(div_err && result_valid));

  assert_valid_single_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  assert_result_held_R9: assert property (@(posedge clk) disable iff (rst)
    (!result_valid && !$past(rst)) |-> $stable(result_mc));

endmodule

bind tsense_linearizer tlin_checks #(.RES_W(RES_W), .CAL_W(tlin_pkg::COEF_W)) u_tlin_checks (
  .clk          (clk),
  .rst          (rst),
  .sample_valid (sample_valid),
  .busy         (busy),
  .result_valid (result_valid),
  .result_mc    (result_mc),
  .div_err      (div_err),
  .cal_now      (cal_live)
);

// File: tb/tsense_linearizer_tb_top.sv
module tsense_linearizer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        preset_load = 1'b0;
  logic        preset_sel = 1'b0;
  logic        coef_we = 1'b0;
  logic [1:0]  coef_addr = 2'd0;
  logic [31:0] coef_wdata = 32'd0;
  logic [31:0] freq_hz = 32'd0;
  logic        sample_valid = 1'b0;
  logic [31:0] sample_raw = 32'd0;
  logic        busy;
  logic        result_valid;
  logic signed [31:0] result_mc;
  logic        div_err;

  int n_checks = 0;
  int n_err = 0;
  bit finished = 0;

  logic [31:0]        m_h, m_g, m_c;
  logic signed [31:0] m_j;

  always #2 clk = ~clk;

  tsense_linearizer dut_i (
    .clk          (clk),
    .rst          (rst),
    .preset_load  (preset_load),
    .preset_sel   (preset_sel),
    .coef_we      (coef_we),
    .coef_addr    (coef_addr),
    .coef_wdata   (coef_wdata),
    .freq_hz      (freq_hz),
    .sample_valid (sample_valid),
    .sample_raw   (sample_raw),
    .busy         (busy),
    .result_valid (result_valid),
    .result_mc    (result_mc),
    .div_err      (div_err)
  );

  function automatic longint ref_temp(input logic [31:0] h, input logic [31:0] g,
                                      input logic signed [31:0] j, input logic [31:0] c,
                                      input logic [31:0] f, input logic [15:0] n);
    longint hl, gl, jl, cl, fl, nl, t;
    hl = longint'({32'd0, h});
    gl = longint'({32'd0, g});
    jl = longint'(j);
    cl = longint'({32'd0, c});
    fl = longint'({32'd0, f});
    nl = longint'({48'd0, n});
    t = gl + (hl * nl) / cl - hl / 2 + (jl * fl) / 1000000;
    if (t < -40000) t = -40000;
    if (t > 125000) t = 125000;
    return t;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_preset(input logic sel);
    @(negedge clk);
    preset_load = 1'b1;
    preset_sel = sel;
    @(negedge clk);
    preset_load = 1'b0;
    if (sel) begin
      m_h = 249400; m_g = 57400; m_j = 0; m_c = 4096;
    end else begin
      m_h = 200000; m_g = 60000; m_j = -100; m_c = 4094;
    end
  endtask

  task automatic wcoef(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    coef_we = 1'b1;
    coef_addr = a;
    coef_wdata = d;
    @(negedge clk);
    coef_we = 1'b0;
    case (a)
      2'd0: m_h = d;
      2'd1: m_g = d;
      2'd2: m_j = $signed(d);
      default: m_c = d;
    endcase
  endtask

  task automatic wait_out(output longint res, output bit got_res, output bit got_err);
    for (int k = 0; k < 400; k++) begin
      if (result_valid || div_err) break;
      @(negedge clk);
    end
    got_res = result_valid;
    got_err = div_err;
    res = longint'(result_mc);
  endtask

  task automatic convert(input logic [31:0] raw, output longint res,
                         output bit got_res, output bit got_err);
    @(negedge clk);
    sample_valid = 1'b1;
    sample_raw = raw;
    @(negedge clk);
    sample_valid = 1'b0;
    wait_out(res, got_res, got_err);
  endtask

  task automatic conv_check(input logic [31:0] raw, input string req);
    longint r, e;
    bit gr, ge;
    e = ref_temp(m_h, m_g, m_j, m_c, freq_hz, raw[15:0]);
    convert(raw, r, gr, ge);
    chk(gr && !ge, req, longint'(gr), 1);
    chk(r == e, req, r, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    longint r, r2, e;
    bit gr, ge;
    int pulses;
    logic signed [31:0] held;
    void'($urandom(32'd12345));
    m_h = 200000; m_g = 60000; m_j = -100; m_c = 4094;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy, "R1 busy", longint'(busy), 0);
    chk(!result_valid, "R1 result_valid", longint'(result_valid), 0);
    chk(!div_err, "R1 div_err", longint'(div_err), 0);
    chk(result_mc == 0, "R1 result", longint'(result_mc), 0);

    // R1/R2 default preset: 60000 + 100000 - 100000 - 10000
    freq_hz = 32'd100000000;
    convert(32'd2047, r, gr, ge);
    chk(gr && r == 50000, "R1 default preset", r, 50000);

    // R5 second preset
    set_preset(1'b1);
    freq_hz = 32'd50000000;
    convert(32'd1024, r, gr, ge);
    chk(gr && r == -4950, "R5 second preset", r, -4950);

    // R5 back to first preset, R3 lower boundary and upper clamp
    set_preset(1'b0);
    freq_hz = 32'd0;
    convert(32'd0, r, gr, ge);
    chk(r == -40000, "R3 low edge", r, -40000);
    convert(32'd4094, r, gr, ge);
    chk(r == 125000, "R3 high clamp", r, 125000);
    wcoef(2'd1, 32'd0);
    convert(32'd0, r, gr, ge);
    chk(r == -40000, "R3 low clamp", r, -40000);

    // R4 upper bits ignored
    set_preset(1'b0);
    freq_hz = 32'd100000000;
    convert(32'hABCD_07FF, r, gr, ge);
    chk(r == 50000, "R4 upper bits", r, 50000);

    // R2/R6 negative correction truncates toward zero: -7*1.5e6/1e6 = -10
    wcoef(2'd0, 32'd0);
    wcoef(2'd1, 32'd1000);
    wcoef(2'd2, 32'hFFFF_FFF9);
    wcoef(2'd3, 32'd3);
    freq_hz = 32'd1500000;
    convert(32'd5, r, gr, ge);
    chk(r == 990, "R2 trunc toward zero", r, 990);
    // R6 gain/full-scale truncation: 1000 + 7*5/3 - 3 + 0
    wcoef(2'd0, 32'd7);
    wcoef(2'd2, 32'd0);
    conv_check(32'd5, "R6 override");

    // R7 sample during busy ignored
    set_preset(1'b0);
    freq_hz = 32'd100000000;
    e = ref_temp(m_h, m_g, m_j, m_c, freq_hz, 16'd100);
    @(negedge clk);
    sample_valid = 1'b1;
    sample_raw = 32'd100;
    @(negedge clk);
    chk(busy, "R7 busy rises", longint'(busy), 1);
    sample_raw = 32'd4000;
    @(negedge clk);
    sample_valid = 1'b0;
    pulses = 0;
    r = 0;
    for (int k = 0; k < 400; k++) begin
      if (result_valid) begin
        pulses++;
        r = longint'(result_mc);
        chk(!busy, "R7 busy falls", longint'(busy), 0);
      end
      @(negedge clk);
    end
    chk(pulses == 1, "R7 one result", pulses, 1);
    chk(r == e, "R7 first sample kept", r, e);

    // R9 hold
    held = result_mc;
    repeat (10) @(negedge clk);
    chk(result_mc == held && !result_valid, "R9 hold", longint'(result_mc), longint'(held));

    // R8 zero full-scale count
    wcoef(2'd3, 32'd0);
    convert(32'd50, r, gr, ge);
    chk(ge && !gr, "R8 error pulse", longint'(ge), 1);
    chk(!busy, "R8 busy low", longint'(busy), 0);
    @(negedge clk);
    chk(!div_err, "R8 single pulse", longint'(div_err), 0);
    pulses = 0;
    for (int k = 0; k < 200; k++) begin
      if (result_valid) pulses++;
      @(negedge clk);
    end
    chk(pulses == 0, "R8 no result", pulses, 0);
    chk(result_mc == held, "R8 result untouched", longint'(result_mc), longint'(held));

    // R10 preset beats same-cycle write
    @(negedge clk);
    preset_load = 1'b1;
    preset_sel = 1'b1;
    coef_we = 1'b1;
    coef_addr = 2'd1;
    coef_wdata = 32'd5;
    @(negedge clk);
    preset_load = 1'b0;
    coef_we = 1'b0;
    m_h = 249400; m_g = 57400; m_j = 0; m_c = 4096;
    freq_hz = 32'd50000000;
    convert(32'd1024, r, gr, ge);
    chk(r == -4950, "R10 preset priority", r, -4950);

    // R11 write during conversion does not affect it
    set_preset(1'b0);
    freq_hz = 32'd100000000;
    e = ref_temp(m_h, m_g, m_j, m_c, freq_hz, 16'd3000);
    @(negedge clk);
    sample_valid = 1'b1;
    sample_raw = 32'd3000;
    @(negedge clk);
    sample_valid = 1'b0;
    coef_we = 1'b1;
    coef_addr = 2'd1;
    coef_wdata = 32'd0;
    freq_hz = 32'd7;
    @(negedge clk);
    coef_we = 1'b0;
    m_g = 0;
    wait_out(r, gr, ge);
    chk(gr && r == e, "R11 snapshot", r, e);
    freq_hz = 32'd100000000;
    conv_check(32'd3000, "R11 new offset used");

    // R2 random sweep
    for (int it = 0; it < 40; it++) begin
      wcoef(2'd0, $urandom_range(400000, 0));
      wcoef(2'd1, $urandom_range(120000, 0));
      wcoef(2'd2, 32'($signed($urandom_range(4000, 0)) - 2000));
      wcoef(2'd3, $urandom_range(8192, 1));
      freq_hz = $urandom_range(500000000, 0);
      conv_check($urandom, "R2 random");
    end

    r2 = 0;
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err + int'(r2));
    $finish;
  end

endmodule